// File: doc/BRIEF.md
# Full-Bridge Gate Control with Dead Time

This block is the digital control core of a four-switch full-bridge gate driver. It has two identical half-bridge channels, A and B, and they work independently. Each channel takes a low-side and a high-side command and drives a low-side and a high-side gate enable. The low-side command always wins over the high-side one, so the two switches of a channel are never on together. A gate turns off on the first output edge after its request goes away. A gate turns on only after a programmable dead time, counted in clock cycles. If a channel's high-side command is held high, its low-side command alone steers the leg between its two switches (bistate operation).

Every command, disable and undervoltage input passes through a two-flop synchronizer, and every gate enable comes from a register. A global disable or a logic-supply undervoltage forces all four gates low. A bootstrap undervoltage on a channel blocks only that channel's high gate. When the bridge leaves reset, disable or supply undervoltage, both low gates are driven high for a fixed refresh window so that the bootstrap capacitors recharge. A high gate can follow only after that window and a dead time.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: Channels A and B act independently. A command, or a bootstrap undervoltage, on one channel never changes the other channel's gates.
- R2: While a channel's low-side command is high, its high gate stays low. The low and high gates of one channel are never high in the same cycle.
- R3: While the synchronized disable input is high, all four gates are low. After disable falls, the command inputs regain control once the refresh window of R6 is over.
- R4: An input change is first acted on at the third rising edge after it is applied. A gate turn-off happens at that edge. A gate turn-on happens dead_cycles+1 edges later. The two gates of a channel are therefore both low for at least dead_cycles+1 cycles between one turning off and the other turning on.
- R5: With a channel's high-side command held high, the low-side command high selects the low gate and low selects the high gate, with the dead time of R4 at each transition.
- R6: On leaving reset, disable or supply undervoltage, both low gates go high at the edge where the release is first acted on. They stay high for exactly REFRESH_CYC cycles, with both high gates low. After the window, the commands take over, and a high gate turn-on still waits the dead time of R4.
- R7: While the supply undervoltage input is high, all four gates are low. Its release starts the refresh window of R6.
- R8: A bootstrap undervoltage on a channel forces that channel's high gate low and leaves its low gate under command control. When it clears, a pending high-side command turns on after the dead time.
- R9: If a turn-on request is withdrawn before its dead-time count completes, the gate stays low. A later request counts the full dead time again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dis_i | input | 1 | Global disable, high forces all gates low |
| vdd_uv_i | input | 1 | Logic-supply undervoltage flag |
| a_boot_uv_i | input | 1 | Channel A bootstrap undervoltage flag |
| b_boot_uv_i | input | 1 | Channel B bootstrap undervoltage flag |
| a_lo_cmd_i | input | 1 | Channel A low-side command |
| a_hi_cmd_i | input | 1 | Channel A high-side command |
| b_lo_cmd_i | input | 1 | Channel B low-side command |
| b_hi_cmd_i | input | 1 | Channel B high-side command |
| dead_cycles_i | input | DT_W | Dead time in clock cycles, held static while gates switch |
| a_lo_gate_o | output | 1 | Channel A low-side gate enable |
| a_hi_gate_o | output | 1 | Channel A high-side gate enable |
| b_lo_gate_o | output | 1 | Channel B low-side gate enable |
| b_hi_gate_o | output | 1 | Channel B high-side gate enable |

## Verification
The dead-gap assertion assumes that dead_cycles_i does not change while a channel is counting toward a turn-on. The bench therefore changes it only after both channels have been idle for several cycles. The assertions also assume that REFRESH_CYC is at least 2 and that inputs are asynchronous levels, which the synchronizers absorb. The stimulus changes inputs only on falling clock edges, and it holds each level long enough for the expected transition to complete before the next change. The one exception is the deliberately short request used to test cancellation.

// File: rtl/bgc_pkg.sv
// Shared types for the full-bridge gate controller.
// Assumes: two half-bridge channels, each with one low and one high gate.
package bgc_pkg;

    localparam int NUM_CH = 2;

    // What a leg wants its gates to be doing this cycle
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_LO   = 2'd1,
        REQ_HI   = 2'd2
    } leg_req_e;

    // Bootstrap refresh sequencer states
    typedef enum logic [1:0] {
        RF_HOLD = 2'd0,
        RF_RUN  = 2'd1,
        RF_DONE = 2'd2
    } refresh_st_e;

endpackage

// File: rtl/bgc_sync.sv
// Two-flop synchronizer for a vector of independent level inputs.
// Assumes: each bit is a slow level; no bus coherency is needed across bits.
// RST_VAL lets safety inputs come out of reset in their protective state.
module bgc_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Shift the asynchronous inputs through two register stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;

endmodule

// File: rtl/bgc_refresh.sv
// Bootstrap refresh sequencer shared by both channels.
// Holds while the bridge is forced off. On release it asserts refresh_o for
// exactly REFRESH_CYC cycles and then stays idle until the next force-off.
// Assumes: REFRESH_CYC >= 2; reset behaves like a force-off release.
module bgc_refresh
    import bgc_pkg::*;
#(
    parameter int REFRESH_CYC = 116
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_off_i,
    output logic refresh_o
);

    localparam int RC_W = $clog2(REFRESH_CYC + 1);
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(REFRESH_CYC - 1);

    refresh_st_e     st_q;
    logic [RC_W-1:0] rcnt_q;

    // Track force-off, then time the refresh window after release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RF_HOLD;
            rcnt_q <= '0;
        end else if (force_off_i) begin
            st_q   <= RF_HOLD;
            rcnt_q <= '0;
        end else begin
            unique case (st_q)
                RF_HOLD: begin
                    st_q   <= RF_RUN;
                    rcnt_q <= RC_W'(1);
                end
                RF_RUN: begin
                    if (rcnt_q == RC_LAST) st_q <= RF_DONE;
                    else                   rcnt_q <= rcnt_q + 1'b1;
                end
                default: st_q <= RF_DONE;
            endcase
        end
    end

    // The window opens in the very cycle force-off drops
    assign refresh_o = (st_q != RF_DONE) && !force_off_i;

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RF_RUN) |-> (rcnt_q <= RC_LAST)); // R6

    AST_HOLD_WHILE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        force_off_i |=> (st_q == RF_HOLD)); // R6

endmodule

// File: rtl/bgc_leg.sv
// One half-bridge leg: lockout, dead-time turn-on, immediate turn-off.
// Priority: force-off > refresh (low on) > low command > high command.
// A bootstrap undervoltage removes the high request only.
// Assumes: inputs already synchronized; dead_i static while counting.
module bgc_leg
    import bgc_pkg::*;
#(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lo_cmd_i,
    input  logic            hi_cmd_i,
    input  logic            force_off_i,
    input  logic            refresh_i,
    input  logic            boot_uv_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            lo_gate_o,
    output logic            hi_gate_o
);

    leg_req_e        req;
    leg_req_e        pend_q;
    logic [DT_W-1:0] cnt_q;
    logic            lo_q;
    logic            hi_q;

    // Resolve the inputs into a single request with lockout priority
    always_comb begin
        if (force_off_i)                 req = REQ_NONE;
        else if (refresh_i)              req = REQ_LO;
        else if (lo_cmd_i)               req = REQ_LO;
        else if (hi_cmd_i && !boot_uv_i) req = REQ_HI;
        else                             req = REQ_NONE;
    end

    // Drive gates: drop at once, raise only after dead_i+1 stable cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= 1'b0;
            hi_q   <= 1'b0;
            cnt_q  <= '0;
            pend_q <= REQ_NONE;
        end else begin
            pend_q <= req;
            unique case (req)
                REQ_NONE: begin
                    lo_q  <= 1'b0;
                    hi_q  <= 1'b0;
                    cnt_q <= '0;
                end
                REQ_LO: begin
                    hi_q <= 1'b0;
                    if (refresh_i) begin
                        lo_q  <= 1'b1;
                        cnt_q <= '0;
                    end else if (lo_q) begin
                        cnt_q <= '0;
                    end else if (hi_q || pend_q != REQ_LO) begin
                        cnt_q <= '0;
                    end else if (cnt_q == dead_i) begin
                        lo_q  <= 1'b1;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    lo_q <= 1'b0;
                    if (hi_q) begin
                        cnt_q <= '0;
                    end else if (lo_q || pend_q != REQ_HI) begin
                        cnt_q <= '0;
                    end else if (cnt_q == dead_i) begin
                        hi_q  <= 1'b1;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign lo_gate_o = lo_q;
    assign hi_gate_o = hi_q;

    // Checker-only count of consecutive cycles with both gates low
    logic [DT_W:0] off_run_q;

    // Measure the off gap that precedes each high-side turn-on
    always_ff @(posedge clk) begin
        if (!rst_n)                        off_run_q <= '0;
        else if (lo_q || hi_q)             off_run_q <= '0;
        else if (off_run_q != '1)          off_run_q <= off_run_q + 1'b1;
    end

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_q && hi_q)); // R2

    AST_LO_CMD_BLOCKS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cmd_i |=> !hi_q); // R2

    AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        force_off_i |=> (!lo_q && !hi_q)); // R3

    AST_BOOT_UV_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        boot_uv_i |=> !hi_q); // R8

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_q) |-> (off_run_q > {1'b0, dead_i})); // R4

endmodule

// File: rtl/bridge_gate_ctrl.sv
// Full-bridge gate controller top: synchronizes all inputs, runs the shared
// bootstrap refresh sequencer and one leg per channel.
// Assumes: dead_cycles_i is a static configuration value; REFRESH_CYC >= 2.
module bridge_gate_ctrl
    import bgc_pkg::*;
#(
    parameter int DT_W        = 10,
    parameter int REFRESH_CYC = 116
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dis_i,
    input  logic            vdd_uv_i,
    input  logic            a_boot_uv_i,
    input  logic            b_boot_uv_i,
    input  logic            a_lo_cmd_i,
    input  logic            a_hi_cmd_i,
    input  logic            b_lo_cmd_i,
    input  logic            b_hi_cmd_i,
    input  logic [DT_W-1:0] dead_cycles_i,
    output logic            a_lo_gate_o,
    output logic            a_hi_gate_o,
    output logic            b_lo_gate_o,
    output logic            b_hi_gate_o
);

    localparam int SYNC_W = 3 * NUM_CH + 2;
    localparam int DIS_BIT = 3 * NUM_CH;
    localparam int UV_BIT  = 3 * NUM_CH + 1;
    // Disable and supply UV leave reset asserted so the bridge stays off
    localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(2'b11) << DIS_BIT;

    logic [SYNC_W-1:0] sync_in;
    logic [SYNC_W-1:0] sync_out;
    logic [NUM_CH-1:0] lo_cmd_s;
    logic [NUM_CH-1:0] hi_cmd_s;
    logic [NUM_CH-1:0] boot_uv_s;
    logic              dis_s;
    logic              vdd_uv_s;
    logic              force_off;
    logic              refresh;
    logic [NUM_CH-1:0] lo_gate;
    logic [NUM_CH-1:0] hi_gate;

    assign sync_in = {vdd_uv_i, dis_i,
                      b_boot_uv_i, a_boot_uv_i,
                      b_hi_cmd_i, a_hi_cmd_i,
                      b_lo_cmd_i, a_lo_cmd_i};

    bgc_sync #(
        .W       (SYNC_W),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sync_in),
        .q_o   (sync_out)
    );

    assign lo_cmd_s  = sync_out[NUM_CH-1:0];
    assign hi_cmd_s  = sync_out[2*NUM_CH-1:NUM_CH];
    assign boot_uv_s = sync_out[3*NUM_CH-1:2*NUM_CH];
    assign dis_s     = sync_out[DIS_BIT];
    assign vdd_uv_s  = sync_out[UV_BIT];
    assign force_off = dis_s | vdd_uv_s;

    bgc_refresh #(
        .REFRESH_CYC (REFRESH_CYC)
    ) u_refresh (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_off_i (force_off),
        .refresh_o   (refresh)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_leg
        bgc_leg #(
            .DT_W (DT_W)
        ) u_leg (
            .clk         (clk),
            .rst_n       (rst_n),
            .lo_cmd_i    (lo_cmd_s[ch]),
            .hi_cmd_i    (hi_cmd_s[ch]),
            .force_off_i (force_off),
            .refresh_i   (refresh),
            .boot_uv_i   (boot_uv_s[ch]),
            .dead_i      (dead_cycles_i),
            .lo_gate_o   (lo_gate[ch]),
            .hi_gate_o   (hi_gate[ch])
        );
    end

    assign a_lo_gate_o = lo_gate[0];
    assign a_hi_gate_o = hi_gate[0];
    assign b_lo_gate_o = lo_gate[1];
    assign b_hi_gate_o = hi_gate[1];

    AST_REFRESH_LO_ON: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (a_lo_gate_o && b_lo_gate_o)); // R6

    AST_REFRESH_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (!a_hi_gate_o && !b_hi_gate_o)); // R6

    AST_SUPPLY_UV_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_uv_s |=> !(a_lo_gate_o || a_hi_gate_o || b_lo_gate_o || b_hi_gate_o)); // R7

    AST_DISABLE_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        dis_s |=> !(a_lo_gate_o || a_hi_gate_o || b_lo_gate_o || b_hi_gate_o)); // R3

endmodule

// File: tb/test_bridge_gate_ctrl.sv
// Scoreboard bench: stimulus steps queue expected gate vectors by cycle,
// a monitor pops and compares them on the falling edge.
// Gate vector order: {b_hi, b_lo, a_hi, a_lo}.
module test_bridge_gate_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DT_W = 10;
    localparam int REF  = 116;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dis = 1'b0, vdd_uv = 1'b0, a_buv = 1'b0, b_buv = 1'b0;
    logic a_lo = 1'b0, a_hi = 1'b0, b_lo = 1'b0, b_hi = 1'b0;
    logic [DT_W-1:0] dead = DT_W'(3);
    logic a_lo_g, a_hi_g, b_lo_g, b_hi_g;
    logic [3:0] gates;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int n, m, d;
    bit done = 1'b0;

    int         q_cyc[$];
    logic [3:0] q_val[$];
    string      q_tag[$];

    bridge_gate_ctrl #(.DT_W(DT_W), .REFRESH_CYC(REF)) i_bridge_gate_ctrl (
        .clk (clk), .rst_n (rst_n), .dis_i (dis), .vdd_uv_i (vdd_uv),
        .a_boot_uv_i (a_buv), .b_boot_uv_i (b_buv),
        .a_lo_cmd_i (a_lo), .a_hi_cmd_i (a_hi),
        .b_lo_cmd_i (b_lo), .b_hi_cmd_i (b_hi),
        .dead_cycles_i (dead),
        .a_lo_gate_o (a_lo_g), .a_hi_gate_o (a_hi_g),
        .b_lo_gate_o (b_lo_g), .b_hi_gate_o (b_hi_g)
    );

    assign gates = {b_hi_g, b_lo_g, a_hi_g, a_lo_g};

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Queue an expectation, kept sorted by cycle
    task automatic expect_at(input int c, input logic [3:0] v, input string tag);
        int idx = q_cyc.size();
        for (int i = 0; i < q_cyc.size(); i++) begin
            if (q_cyc[i] > c) begin
                idx = i;
                break;
            end
        end
        q_cyc.insert(idx, c);
        q_val.insert(idx, v);
        q_tag.insert(idx, tag);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic drain();
        while (q_cyc.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare due expectations away from the active edge
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            checks++;
            if (q_cyc[0] < cyc) begin
                errors++;
                $display("FAIL %s: expectation for cycle %0d missed (now %0d) expected %b",
                         q_tag[0], q_cyc[0], cyc, q_val[0]);
            end else if (gates !== q_val[0]) begin
                errors++;
                $display("FAIL %s: cycle %0d gates actual %b expected %b",
                         q_tag[0], cyc, gates, q_val[0]);
            end
            void'(q_cyc.pop_front());
            void'(q_val.pop_front());
            void'(q_tag.pop_front());
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        d = 3;
        // Reset and power-on refresh (R6)
        expect_at(3, 4'b0000, "R6 reset state");
        expect_at(6, 4'b0000, "R6 pre-refresh");
        expect_at(7, 4'b0101, "R6 refresh start");
        expect_at(6 + REF, 4'b0101, "R6 refresh last cycle");
        expect_at(7 + REF, 4'b0000, "R6 refresh end");
        wait_cyc(4);
        rst_n = 1'b1;
        drain();

        // R4: low gate turn-on delay
        n = cyc; a_lo = 1'b1;
        expect_at(n + 3 + d, 4'b0000, "R4 before dead end");
        expect_at(n + 4 + d, 4'b0001, "R4 low turn-on");
        drain();

        // R4: switch low to high
        n = cyc; a_lo = 1'b0; a_hi = 1'b1;
        expect_at(n + 3, 4'b0000, "R4 immediate turn-off");
        expect_at(n + 3 + d, 4'b0000, "R4 dead gap");
        expect_at(n + 4 + d, 4'b0010, "R4 high turn-on");
        drain();

        // R2/R5: bistate, low command wins over held high command
        n = cyc; a_lo = 1'b1;
        expect_at(n + 3, 4'b0000, "R2 high dropped by low cmd");
        expect_at(n + 4 + d, 4'b0001, "R5 low selected");
        expect_at(n + 12 + d, 4'b0001, "R2 high stays low");
        drain();
        n = cyc; a_lo = 1'b0;
        expect_at(n + 3, 4'b0000, "R5 low off");
        expect_at(n + 4 + d, 4'b0010, "R5 high selected");
        drain();

        // R8/R1: bootstrap UV on A, B driven independently
        n = cyc; a_buv = 1'b1; b_lo = 1'b1;
        expect_at(n + 3, 4'b0000, "R8 boot UV drops A high");
        expect_at(n + 4 + d, 4'b0100, "R1 B low on, A unaffected");
        expect_at(n + 20, 4'b0100, "R8 A high held off");
        drain();
        n = cyc; a_buv = 1'b0;
        expect_at(n + 3 + d, 4'b0100, "R8 dead after UV clear");
        expect_at(n + 4 + d, 4'b0110, "R8 A high back");
        drain();

        // R1: B switches to high while A holds
        n = cyc; b_lo = 1'b0; b_hi = 1'b1;
        expect_at(n + 3, 4'b0010, "R1 B low off, A kept");
        expect_at(n + 4 + d, 4'b1010, "R1 B high on");
        drain();

        // R3/R6: disable then release with high commands pending
        n = cyc; dis = 1'b1;
        expect_at(n + 3, 4'b0000, "R3 disable all off");
        expect_at(n + 30, 4'b0000, "R3 held off");
        drain();
        m = cyc; dis = 1'b0;
        expect_at(m + 2, 4'b0000, "R3 still off");
        expect_at(m + 3, 4'b0101, "R6 refresh after disable");
        expect_at(m + 2 + REF, 4'b0101, "R6 refresh width");
        expect_at(m + 3 + REF, 4'b0000, "R6 refresh ends");
        expect_at(m + 3 + REF + d, 4'b0000, "R6 dead after refresh");
        expect_at(m + 4 + REF + d, 4'b1010, "R3 commands regain control");
        drain();

        // R7: supply undervoltage
        n = cyc; vdd_uv = 1'b1;
        expect_at(n + 3, 4'b0000, "R7 supply UV all off");
        expect_at(n + 15, 4'b0000, "R7 held off");
        drain();
        m = cyc; vdd_uv = 1'b0;
        expect_at(m + 3, 4'b0101, "R7 refresh after UV");
        expect_at(m + 3 + REF, 4'b0000, "R7 refresh ends");
        expect_at(m + 4 + REF + d, 4'b1010, "R7 high back");
        drain();

        // R9: cancelled request restarts count
        n = cyc; a_hi = 1'b0; b_hi = 1'b0;
        expect_at(n + 3, 4'b0000, "R9 idle");
        drain();
        n = cyc; a_lo = 1'b1;
        expect_at(n + 8, 4'b0000, "R9 short request cancelled");
        expect_at(n + 12, 4'b0000, "R9 count restarted");
        expect_at(n + 13, 4'b0001, "R9 full dead then on");
        wait_cyc(n + 2); a_lo = 1'b0;
        wait_cyc(n + 6); a_lo = 1'b1;
        drain();

        // R4: zero dead time
        n = cyc; a_lo = 1'b0;
        expect_at(n + 3, 4'b0000, "R4 idle");
        drain();
        dead = '0; d = 0;
        repeat (4) @(negedge clk);
        n = cyc; a_lo = 1'b1;
        expect_at(n + 3, 4'b0000, "R4 zero dead before");
        expect_at(n + 4, 4'b0001, "R4 zero dead low on");
        drain();
        n = cyc; a_lo = 1'b0; a_hi = 1'b1;
        expect_at(n + 3, 4'b0000, "R4 zero dead break cycle");
        expect_at(n + 4, 4'b0010, "R4 zero dead high on");
        drain();

        // R4: long dead time on channel B
        n = cyc; a_hi = 1'b0;
        expect_at(n + 3, 4'b0000, "R4 idle");
        drain();
        dead = DT_W'(12); d = 12;
        repeat (4) @(negedge clk);
        n = cyc; b_lo = 1'b1;
        expect_at(n + 3 + d, 4'b0000, "R4 long dead before");
        expect_at(n + 4 + d, 4'b0100, "R4 long dead B low on");
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule